// File: doc/BRIEF.md
# Half-Duplex Command/Reply Serial Frame Master

This block is the master side of a half-duplex serial exchange. One frame carries an 8-bit command out to a slave. The reply then comes back on a separate input. A start pulse latches the command byte and a requested reply length, and it pulls the active-low select line down. From then on, the block moves the serial clock only when an external bit-rate generator sends a rise strobe or a fall strobe. Between frames the serial clock rests low.

The command leaves most significant bit first. Outbound data changes after a falling edge of the serial clock, and the slave samples it on the rising edge. After the eighth command clock, the slave gets one full serial clock to turn around. During that clock nothing is sampled. The reply, 4 to 16 bits long, is sampled on the rising edges that follow. The reply word is right-justified on the output. One half-clock after the last reply bit is taken, the select line goes high again and a one-cycle done pulse marks that the word is valid.

Top module: `mw_frame_master`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o is 0, sdo_o is 0, done_o is 0 and rsp_o is all zeros.
- R2: A start_i pulse while no frame is running pulls cs_n_o low on the next clock edge and puts command bit 7 on sdo_o. A start_i pulse during a running frame is ignored, and so are cmd_i and rsp_len_i values presented with it.
- R3: sclk_o is low whenever cs_n_o is high. During a frame, a rise strobe raises sclk_o only if it is low, and a fall strobe lowers it only if it is high. Strobes have no effect between frames.
- R4: The command goes out MSB first. At serial rising edge k (k = 1..8), sdo_o carries command bit 8-k. sdo_o changes only after a serial falling edge or when a frame starts.
- R5: sdi_i is never captured during the eight command clocks or the turnaround clock, whatever its value.
- R6: The ninth serial clock is a turnaround clock with no sampling. From the falling edge after the eighth rising edge until the frame ends, sdo_o is 0.
- R7: The reply length N is rsp_len_i, clamped to the range 4..16. Values below 4 give 4 and values above 16 give 16. A frame has exactly 9+N rising serial edges.
- R8: Reply bits are sampled on rising edges 10..9+N, the first one being the reply's MSB. rsp_o holds the N bits right-justified, with zeros above them.
- R9: On the fall strobe that follows the last reply rising edge, sclk_o falls and cs_n_o rises in the same cycle. done_o is 1 for exactly that one cycle, and rsp_o changes to the new reply then and holds until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a frame (acted on only when idle) |
| cmd_i | input | 8 | Command byte to send |
| rsp_len_i | input | 5 | Requested reply length in bits (clamped to 4..16) |
| rise_stb_i | input | 1 | Bit-rate strobe: raise the serial clock |
| fall_stb_i | input | 1 | Bit-rate strobe: lower the serial clock |
| sdi_i | input | 1 | Serial data from the slave |
| sclk_o | output | 1 | Serial clock, low when idle |
| cs_n_o | output | 1 | Active-low frame select |
| sdo_o | output | 1 | Serial data to the slave |
| rsp_o | output | 16 | Last reply, right-justified |
| done_o | output | 1 | One-cycle pulse when a frame ends |

## Verification
If the edge counter drifts, the error shows at the ports within the same frame. The number of rising serial edges under a low select no longer equals 9+N, and the select line rises half a clock early or late. If the command register gets an extra shift, or misses one, a wrong bit appears on sdo_o at the very next rising edge. If the sampling window is off by one clock, the reply word picks up a junk 1 that the slave drives during the command phase, or it loses its LSB. That difference appears on rsp_o in the cycle where done_o pulses.

// File: rtl/mw_pkg.sv
package mw_pkg;

   // per-cycle control strobes passed from the sequencer to the datapaths
   typedef struct packed {
      logic launch;   // frame accepted this cycle
      logic fall;     // serial clock falls this cycle
      logic sample;   // capture sdi this cycle (reply window)
      logic finish;   // last falling edge of the frame
   } mw_ctl_t;

endpackage

// File: rtl/mw_seq.sv
module mw_seq
   import mw_pkg::*;
#(
   parameter int CMD_W   = 8,
   parameter int GAP_W   = 1,
   parameter int MIN_RSP = 4,
   parameter int MAX_RSP = 16,
   parameter int LEN_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             rise_stb_i,
   input  logic             fall_stb_i,
   input  logic [LEN_W-1:0] len_i,
   output mw_ctl_t          ctl_o,
   output logic             sclk_o,
   output logic             cs_n_o,
   output logic             done_o
);

   localparam int TOT_MAX = CMD_W + GAP_W + MAX_RSP;
   localparam int CNT_W   = $clog2(TOT_MAX + 1);
   localparam logic [LEN_W-1:0] LEN_LO = LEN_W'(MIN_RSP);
   localparam logic [LEN_W-1:0] LEN_HI = LEN_W'(MAX_RSP);
   localparam logic [CNT_W-1:0] HDR_CLKS = CNT_W'(CMD_W + GAP_W);

   logic             active_q, sclk_q, cs_n_q, done_q;
   logic [CNT_W-1:0] rcnt_q, total_q;
   logic [LEN_W-1:0] len_pick;
   logic             launch, do_rise, do_fall, last_fall, in_reply;

   always_comb begin
      if (len_i < LEN_LO)      len_pick = LEN_LO;
      else if (len_i > LEN_HI) len_pick = LEN_HI;
      else                     len_pick = len_i;
   end

   assign launch    = start_i & ~active_q;
   assign do_rise   = active_q & rise_stb_i & ~sclk_q;
   assign do_fall   = active_q & fall_stb_i & sclk_q;
   assign last_fall = do_fall & (rcnt_q == total_q);
   assign in_reply  = (rcnt_q >= HDR_CLKS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         sclk_q   <= 1'b0;
         cs_n_q   <= 1'b1;
         done_q   <= 1'b0;
         rcnt_q   <= '0;
         total_q  <= '0;
      end else begin
         done_q <= last_fall;
         if (launch) begin
            active_q <= 1'b1;
            cs_n_q   <= 1'b0;
            rcnt_q   <= '0;
            total_q  <= HDR_CLKS + CNT_W'(len_pick);
         end else begin
            if (do_rise) begin
               sclk_q <= 1'b1;
               rcnt_q <= rcnt_q + CNT_W'(1);
            end
            if (do_fall) sclk_q <= 1'b0;
            if (last_fall) begin
               active_q <= 1'b0;
               cs_n_q   <= 1'b1;
            end
         end
      end
   end

   assign ctl_o.launch = launch;
   assign ctl_o.fall   = do_fall;
   assign ctl_o.sample = do_rise & in_reply;
   assign ctl_o.finish = last_fall;
   assign sclk_o = sclk_q;
   assign cs_n_o = cs_n_q;
   assign done_o = done_q;

   // R3: no serial clock activity outside a frame
   assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_q |-> !sclk_q);
   // R9: done is a single-cycle pulse
   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);
   // R9: done coincides with select release
   assert_cs_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> $rose(cs_n_q));
   // R7: edge count never passes the frame length
   assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      active_q |-> (rcnt_q <= total_q));

endmodule

// File: rtl/mw_tx_shift.sv
module mw_tx_shift #(
   parameter int W         = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] data_i,
   input  logic         shift_i,
   output logic         sdo_o
);

   logic [W-1:0] sh_q;

   generate
      if (MSB_FIRST) begin : g_msb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sh_q <= '0;
            else if (load_i)  sh_q <= data_i;
            else if (shift_i) sh_q <= {sh_q[W-2:0], 1'b0};
         end
         assign sdo_o = sh_q[W-1];
      end else begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sh_q <= '0;
            else if (load_i)  sh_q <= data_i;
            else if (shift_i) sh_q <= {1'b0, sh_q[W-1:1]};
         end
         assign sdo_o = sh_q[0];
      end
   endgenerate

   // R4: outbound data moves only on a load or a falling serial edge
   assert_sdo_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(load_i || shift_i) |=> $stable(sdo_o));

endmodule

// File: rtl/mw_rx_shift.sv
module mw_rx_shift #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic         sample_i,
   input  logic         sdi_i,
   input  logic         commit_i,
   output logic [W-1:0] word_o
);

   logic [W-1:0] sh_q, word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         word_q <= '0;
      end else begin
         if (clear_i)       sh_q <= '0;
         else if (sample_i) sh_q <= {sh_q[W-2:0], sdi_i};
         if (commit_i)      word_q <= sh_q;
      end
   end

   assign word_o = word_q;

   // R5: capture register only moves in the reply window or on a new frame
   assert_rx_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(clear_i || sample_i) |=> $stable(sh_q));
   // R9: published word changes only at frame end
   assert_word_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> $stable(word_q));

endmodule

// File: rtl/mw_frame_master.sv
module mw_frame_master
   import mw_pkg::*;
#(
   parameter int CMD_W         = 8,
   parameter int GAP_W         = 1,
   parameter int MIN_RSP       = 4,
   parameter int MAX_RSP       = 16,
   parameter bit CMD_MSB_FIRST = 1'b1,
   parameter int LEN_W         = $clog2(MAX_RSP + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [CMD_W-1:0]   cmd_i,
   input  logic [LEN_W-1:0]   rsp_len_i,
   input  logic               rise_stb_i,
   input  logic               fall_stb_i,
   input  logic               sdi_i,
   output logic               sclk_o,
   output logic               cs_n_o,
   output logic               sdo_o,
   output logic [MAX_RSP-1:0] rsp_o,
   output logic               done_o
);

   generate
      if (CMD_W < 2) begin : g_bad_cmd
         $error("mw_frame_master: CMD_W must be at least 2");
      end
      if (MIN_RSP < 2 || MIN_RSP > MAX_RSP) begin : g_bad_rsp
         $error("mw_frame_master: need 2 <= MIN_RSP <= MAX_RSP");
      end
      if (GAP_W < 0) begin : g_bad_gap
         $error("mw_frame_master: GAP_W must not be negative");
      end
      if (LEN_W < $clog2(MAX_RSP + 1)) begin : g_bad_lenw
         $error("mw_frame_master: LEN_W too narrow for MAX_RSP");
      end
   endgenerate

   mw_ctl_t ctl;

   mw_seq #(
      .CMD_W  (CMD_W),
      .GAP_W  (GAP_W),
      .MIN_RSP(MIN_RSP),
      .MAX_RSP(MAX_RSP),
      .LEN_W  (LEN_W)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .rise_stb_i(rise_stb_i),
      .fall_stb_i(fall_stb_i),
      .len_i     (rsp_len_i),
      .ctl_o     (ctl),
      .sclk_o    (sclk_o),
      .cs_n_o    (cs_n_o),
      .done_o    (done_o)
   );

   mw_tx_shift #(
      .W        (CMD_W),
      .MSB_FIRST(CMD_MSB_FIRST)
   ) tx_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (ctl.launch),
      .data_i (cmd_i),
      .shift_i(ctl.fall),
      .sdo_o  (sdo_o)
   );

   mw_rx_shift #(
      .W(MAX_RSP)
   ) rx_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (ctl.launch),
      .sample_i(ctl.sample),
      .sdi_i   (sdi_i),
      .commit_i(ctl.finish),
      .word_o  (rsp_o)
   );

   // R6: after the command bits are gone, sdo stays low to the frame end
   assert_sdo_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.sample && !sdo_o) |=> !sdo_o);

endmodule

// File: tb/mw_frame_master_tb.sv
`timescale 1ns/100ps
module mw_frame_master_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  cmd_i = '0;
   logic [4:0]  rsp_len_i = '0;
   logic        rise_stb_i = 1'b0;
   logic        fall_stb_i = 1'b0;
   logic        sdi_i = 1'b1;
   logic        sclk_o, cs_n_o, sdo_o, done_o;
   logic [15:0] rsp_o;

   int tests = 0;
   int fails = 0;
   int h_cfg = 2;
   int ph = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   mw_frame_master dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmd_i(cmd_i),
      .rsp_len_i(rsp_len_i), .rise_stb_i(rise_stb_i), .fall_stb_i(fall_stb_i),
      .sdi_i(sdi_i), .sclk_o(sclk_o), .cs_n_o(cs_n_o), .sdo_o(sdo_o),
      .rsp_o(rsp_o), .done_o(done_o)
   );

   // free-running bit-rate strobes, half period h_cfg cycles
   always @(negedge clk) begin
      if (!rst_n) begin
         ph = 0;
         rise_stb_i = 1'b0;
         fall_stb_i = 1'b0;
      end else begin
         rise_stb_i = (ph == 0);
         fall_stb_i = (ph == h_cfg);
         ph = (ph + 1) % (2 * h_cfg);
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_frame(input logic [7:0] cmd, input int lreq,
                            input logic [15:0] rep, input bit poke);
      int neff, rises, sdo_bad, cs_bad, k;
      logic [7:0] got;
      logic [15:0] mask, expv;
      bit prev, s, poked, seen_done;
      neff = (lreq < 4) ? 4 : ((lreq > 16) ? 16 : lreq);
      mask = (neff == 16) ? 16'hFFFF : ((16'd1 << neff) - 16'd1);
      expv = rep & mask;
      rises = 0; sdo_bad = 0; cs_bad = 0; got = '0;
      prev = 1'b0; poked = 1'b0; seen_done = 1'b0;
      sdi_i = 1'b1;   // junk during command phase, must be ignored (R5)
      @(negedge clk);
      start_i = 1'b1; cmd_i = cmd; rsp_len_i = 5'(lreq);
      @(negedge clk);
      start_i = 1'b0;
      chk(cs_n_o == 1'b0, "R2 select low after start", cs_n_o, 0);
      chk(sdo_o == cmd[7], "R2 MSB presented", sdo_o, cmd[7]);
      for (k = 0; k < 4000; k++) begin
         if (k != 0) @(negedge clk);
         if (start_i) start_i = 1'b0;
         s = sclk_o;
         if (s && cs_n_o) cs_bad++;
         if (!done_o && cs_n_o) cs_bad++;
         if (s && !prev) begin
            rises++;
            if (rises <= 8) got = {got[6:0], sdo_o};
            else if (sdo_o) sdo_bad++;
         end
         if (!s && prev) begin
            if (rises >= 9 && (rises - 9) < neff) sdi_i = rep[neff - 1 - (rises - 9)];
            else sdi_i = 1'b1;
         end
         if (done_o) begin
            seen_done = 1'b1;
            chk(cs_n_o == 1'b1 && !s, "R9 select and clock released with done",
                {cs_n_o, s}, 2'b10);
            chk(rsp_o == expv, "R8 reply word", rsp_o, expv);
            chk(rsp_o == expv, "R5 no capture in command/turnaround", rsp_o, expv);
            break;
         end
         if (poke && rises == 3 && !poked) begin
            poked = 1'b1;
            start_i = 1'b1; cmd_i = ~cmd; rsp_len_i = 5'd9;
         end
         prev = s;
      end
      chk(seen_done, "R9 frame finished", seen_done, 1);
      chk(got == cmd, poke ? "R2 restart ignored, command bits" : "R4 command bits",
          got, cmd);
      chk(rises == 9 + neff, "R7 rising edge count", rises, 9 + neff);
      chk(sdo_bad == 0, "R6 sdo low after command", sdo_bad, 0);
      chk(cs_bad == 0, "R3 select/clock consistency in frame", cs_bad, 0);
      @(negedge clk);
      chk(done_o == 1'b0, "R9 done single cycle", done_o, 0);
      chk(rsp_o == expv, "R9 reply held", rsp_o, expv);
      cs_bad = 0;
      for (int i = 0; i < 4 * h_cfg + 2; i++) begin
         @(negedge clk);
         if (sclk_o || !cs_n_o || sdo_o) cs_bad++;
      end
      chk(cs_bad == 0, "R3 idle clock low, strobes ignored", cs_bad, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(cs_n_o == 1'b1, "R1 reset select", cs_n_o, 1);
      chk(sclk_o == 1'b0 && sdo_o == 1'b0, "R1 reset clock/data", {sclk_o, sdo_o}, 0);
      chk(done_o == 1'b0 && rsp_o == '0, "R1 reset done/reply", rsp_o, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      for (int h = 1; h <= 3; h++) begin
         h_cfg = h;
         repeat (8) @(negedge clk);
         for (int l = 0; l <= 20; l++) begin
            run_frame(8'(l * 29 + h * 71 + 5),
                      l,
                      16'((l * 1237) ^ (h * 4099) ^ 16'hA5C3),
                      (l % 5) == 2);
         end
      end
      run_frame(8'hFF, 16, 16'hFFFF, 1'b0);
      run_frame(8'h00, 4, 16'h0000, 1'b0);
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL R9 watchdog expired actual=1 expected=0");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule